// File: doc/BRIEF.md
# Synchronized Clock Output Channel Bank

This block drives a bank of clock output channels from one distribution clock. Each channel either passes the distribution clock straight through (bypass mode) or produces a divided clock from its own integer counter. A per-channel enable gates each output. A global enable register bit and a global enable pin each gate the whole bank.

A shared active-low synchronization input re-aligns the divided channels. The input is brought in through a synchronizer and checked for a minimum pulse width. A fixed latency pipeline follows. While the resulting hold is active, every divided channel is forced low and its counter is cleared. When the hold ends, all divided channels rise on the same edge. Bypassed channels keep running through the whole event, so after it they stay edge-aligned with the divided ones.

The configuration words (mode, ratio, enables) are captured on a load strobe. Until the first load, every output stays low.

Top module: `clkChanBank`

## Requirements
- R1: After reset, and until a configuration load sets enables, every channel output is low in both clock phases.
- R2: A channel whose bypass bit (cfgBypass[i]) is 1 and that is enabled outputs the distribution clock: high while distClk is high and low while it is low. This holds also while a sync hold is active.
- R3: A divided channel with ratio field value N (cfgDiv bits [i*DIV_W +: DIV_W]) has a period of N edges. It is high for the first floor(N/2) edges of each period, counting from the edge where it rises after a sync. Field values 0 and 1 act as 2.
- R4: When syncN is held low for two or more cycles, every divided channel is low from the 8th rising edge after the first edge that samples syncN low.
- R5: When syncN returns high after a registered low, all enabled divided channels go high together on the 8th rising edge after the first edge that samples it high.
- R6: A syncN low pulse that lasts a single cycle is ignored: the divided outputs continue without any disturbance.
- R7: If syncN is released before the divided outputs have gone low, they still go low for the registered duration and then rise together, and the resynchronization completes.
- R8: A channel whose enable bit is 0 outputs low. Its counter keeps running, so on re-enable it resumes in phase. A load pulse on cfgLoad takes effect from the edge that samples it.
- R9: A low outEnPin forces all outputs low from the next rising edge. When the pin returns high, the outputs resume in phase from the next rising edge.
- R10: A loaded global enable bit of 0 forces all outputs low. Loading it back to 1 restores them in phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| distClk | input | 1 | Distribution clock |
| rst | input | 1 | Synchronous active-high reset |
| syncN | input | 1 | Active-low synchronization request |
| outEnPin | input | 1 | Global output enable pin, active high |
| cfgLoad | input | 1 | Captures all cfg inputs on the sampling edge |
| cfgGlobalEn | input | 1 | Global enable bit to load |
| cfgBypass | input | NUM_CH | Per-channel mode: 1 bypass, 0 divided |
| cfgChanEn | input | NUM_CH | Per-channel enable bits |
| cfgDiv | input | NUM_CH*DIV_W | Packed per-channel divide ratios |
| chanOut | output | NUM_CH | Channel clock outputs |

## Verification
The bench builds the bank with three channels, 4-bit ratio fields, two synchronizer stages and a four-stage latency pipeline. This brings into reach the mixed configuration of one bypassed channel with divided channels at ratios 2 and 4, and it makes the 8-edge latency exact. A later reload makes channel 0 divided with a ratio field of 0, which reaches the minimum-ratio rule. Each sample is taken in both clock phases, so the bypass passthrough and the fixed divided phase are both visible.

// File: rtl/clkBankPkg.sv
package clkBankPkg;
  // strobes from control to the channel datapath
  typedef struct packed {
    logic holdDiv;  // clear dividers and force divided outputs low
    logic outsOn;   // global gate from pin and register
  } bankStrobe_t;
endpackage

// File: rtl/clkBankCtrl.sv
module clkBankCtrl
  import clkBankPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_LAT    = 4
) (
  input  logic                      distClk,
  input  logic                      rst,
  input  logic                      syncN,
  input  logic                      outEnPin,
  input  logic                      cfgLoad,
  input  logic                      cfgGlobalEn,
  input  logic [NUM_CH-1:0]         cfgBypass,
  input  logic [NUM_CH-1:0]         cfgChanEn,
  input  logic [NUM_CH*DIV_W-1:0]   cfgDiv,
  output bankStrobe_t               strobe,
  output logic [NUM_CH-1:0]         bypassCfg,
  output logic [NUM_CH-1:0]         chanEnCfg,
  output logic [NUM_CH*DIV_W-1:0]   divCfg
);
  localparam int DIV_BITS = NUM_CH * DIV_W;

  logic [SYNC_STAGES-1:0] syncChain;
  logic [PIPE_LAT-1:0]    holdPipe;
  logic syncSeen, syncPrev, syncQual;
  logic pinReg, globalEnReg;

  // metastability chain, reset to the released (high) level
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge distClk)
        if (rst) syncChain[s] <= 1'b1;
        else     syncChain[s] <= syncN;
    end else begin : g_next
      always_ff @(posedge distClk)
        if (rst) syncChain[s] <= 1'b1;
        else     syncChain[s] <= syncChain[s-1];
    end
  end
  assign syncSeen = syncChain[SYNC_STAGES-1];

  // a level change counts only after two agreeing samples
  always_ff @(posedge distClk) begin
    if (rst) begin
      syncPrev <= 1'b1;
      syncQual <= 1'b0;
    end else begin
      syncPrev <= syncSeen;
      if (!syncSeen && !syncPrev)     syncQual <= 1'b1;
      else if (syncSeen && syncPrev)  syncQual <= 1'b0;
    end
  end

  // fixed latency between a registered event and the dividers
  for (genvar p = 0; p < PIPE_LAT; p++) begin : g_pipe
    if (p == 0) begin : g_head
      always_ff @(posedge distClk)
        if (rst) holdPipe[p] <= 1'b0;
        else     holdPipe[p] <= syncQual;
    end else begin : g_tail
      always_ff @(posedge distClk)
        if (rst) holdPipe[p] <= 1'b0;
        else     holdPipe[p] <= holdPipe[p-1];
    end
  end

  always_ff @(posedge distClk) begin
    if (rst) begin
      pinReg      <= 1'b0;
      globalEnReg <= 1'b0;
      bypassCfg   <= '0;
      chanEnCfg   <= '0;
      divCfg      <= DIV_BITS'(0);
    end else begin
      pinReg <= outEnPin;
      if (cfgLoad) begin
        globalEnReg <= cfgGlobalEn;
        bypassCfg   <= cfgBypass;
        chanEnCfg   <= cfgChanEn;
        divCfg      <= cfgDiv;
      end
    end
  end

  assign strobe.holdDiv = holdPipe[PIPE_LAT-1];
  assign strobe.outsOn  = pinReg & globalEnReg;
endmodule

// File: rtl/clkBankPath.sv
module clkBankPath
  import clkBankPkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DIV_W  = 4
) (
  input  logic                    distClk,
  input  logic                    rst,
  input  bankStrobe_t             strobe,
  input  logic [NUM_CH-1:0]       bypassCfg,
  input  logic [NUM_CH-1:0]       chanEnCfg,
  input  logic [NUM_CH*DIV_W-1:0] divCfg,
  output logic [NUM_CH-1:0]       chanOut
);
  localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DIV_W-1:0] divField, ratio, lastCnt, highCnt, cnt;
    logic divOut, chanOn;

    assign divField = divCfg[ch*DIV_W +: DIV_W];
    assign ratio    = (divField < MIN_RATIO) ? MIN_RATIO : divField;
    assign lastCnt  = ratio - 1'b1;
    assign highCnt  = ratio >> 1;

    // counter runs regardless of enable so phase survives gating
    always_ff @(posedge distClk) begin
      if (rst || strobe.holdDiv) begin
        cnt    <= '0;
        divOut <= 1'b0;
      end else begin
        divOut <= (cnt < highCnt);
        cnt    <= (cnt >= lastCnt) ? '0 : cnt + 1'b1;
      end
    end

    assign chanOn      = chanEnCfg[ch] & strobe.outsOn;
    assign chanOut[ch] = chanOn & (bypassCfg[ch] ? distClk : divOut);
  end
endmodule

// File: rtl/clkChanBank.sv
module clkChanBank
  import clkBankPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_LAT    = 4
) (
  input  logic                    distClk,
  input  logic                    rst,
  input  logic                    syncN,
  input  logic                    outEnPin,
  input  logic                    cfgLoad,
  input  logic                    cfgGlobalEn,
  input  logic [NUM_CH-1:0]       cfgBypass,
  input  logic [NUM_CH-1:0]       cfgChanEn,
  input  logic [NUM_CH*DIV_W-1:0] cfgDiv,
  output logic [NUM_CH-1:0]       chanOut
);
  bankStrobe_t              strobe;
  logic [NUM_CH-1:0]        bypassCfg, chanEnCfg;
  logic [NUM_CH*DIV_W-1:0]  divCfg;

  clkBankCtrl #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W),
    .SYNC_STAGES(SYNC_STAGES), .PIPE_LAT(PIPE_LAT)
  ) i_ctrl (
    .distClk(distClk), .rst(rst), .syncN(syncN), .outEnPin(outEnPin),
    .cfgLoad(cfgLoad), .cfgGlobalEn(cfgGlobalEn), .cfgBypass(cfgBypass),
    .cfgChanEn(cfgChanEn), .cfgDiv(cfgDiv), .strobe(strobe),
    .bypassCfg(bypassCfg), .chanEnCfg(chanEnCfg), .divCfg(divCfg)
  );

  clkBankPath #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) i_path (
    .distClk(distClk), .rst(rst), .strobe(strobe), .bypassCfg(bypassCfg),
    .chanEnCfg(chanEnCfg), .divCfg(divCfg), .chanOut(chanOut)
  );
endmodule

// File: rtl/clkChanBankChk.sv
module clkChanBankChk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chanOut,
  input logic [NUM_CH-1:0] bypassMask,
  input logic [NUM_CH-1:0] enMask,
  input logic              outsOn,
  input logic              holdDiv
);
  logic [NUM_CH-1:0] onMask, divOnMask;
  assign onMask    = enMask & {NUM_CH{outsOn}};
  assign divOnMask = onMask & ~bypassMask;

  // R4: an active hold clears every divided output on the next cycle
  assert_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
    holdDiv |=> ((chanOut & ~bypassMask) == '0));

  // R5: end of hold makes every enabled divided output high together
  assert_rise_together_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(holdDiv) |=> ((chanOut & divOnMask) == divOnMask));

  // R6: a hold window is never a single cycle
  assert_hold_min_two_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(holdDiv) |=> holdDiv);

  // R8: a gated channel never shows activity
  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
    ((chanOut & ~onMask) == '0));
endmodule

bind clkChanBank clkChanBankChk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(distClk), .rst(rst), .chanOut(chanOut), .bypassMask(bypassCfg),
  .enMask(chanEnCfg), .outsOn(strobe.outsOn), .holdDiv(strobe.holdDiv)
);

// File: tb/test_clkChanBank.sv
module test_clkChanBank;
  localparam int NUM_CH = 3;
  localparam int DIV_W  = 4;

  logic distClk = 1'b0;
  logic rst = 1'b1, syncN = 1'b1, outEnPin = 1'b1, cfgLoad = 1'b0, cfgGlobalEn = 1'b0;
  logic [NUM_CH-1:0] cfgBypass = '0, cfgChanEn = '0;
  logic [NUM_CH*DIV_W-1:0] cfgDiv = '0;
  logic [NUM_CH-1:0] chanOut;

  clkChanBank #(.NUM_CH(NUM_CH), .DIV_W(DIV_W), .SYNC_STAGES(2), .PIPE_LAT(4)) i_clkChanBank (
    .distClk(distClk), .rst(rst), .syncN(syncN), .outEnPin(outEnPin), .cfgLoad(cfgLoad),
    .cfgGlobalEn(cfgGlobalEn), .cfgBypass(cfgBypass), .cfgChanEn(cfgChanEn),
    .cfgDiv(cfgDiv), .chanOut(chanOut)
  );

  always #10 distClk = ~distClk;  // 50 MHz

  int ecnt = 0;
  always @(posedge distClk) ecnt <= ecnt + 1;

  typedef struct {
    int         edgeNo;
    bit         hiPh;
    logic [2:0] val;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  int checks = 0, fails = 0;
  bit ended = 0;

  // channel ratios used in this bench: ch0 field 0 (acts as 2), ch1 2, ch2 4
  function automatic logic [2:0] patVal(int e, int r, bit hi, logic [2:0] byp, logic [2:0] en);
    logic [2:0] v;
    for (int ch = 0; ch < 3; ch++) begin
      int ratio = (ch == 2) ? 4 : 2;
      if (!en[ch])      v[ch] = 1'b0;
      else if (byp[ch]) v[ch] = hi;
      else              v[ch] = (((e - r) % ratio) < (ratio / 2));
    end
    return v;
  endfunction

  task automatic pushOne(int e, bit hi, logic [2:0] v, string tag);
    expItem_t it;
    it.edgeNo = e; it.hiPh = hi; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pushPat(int from, int to, int r, logic [2:0] byp, logic [2:0] en, string tag);
    for (int e = from; e <= to; e++) begin
      pushOne(e, 1'b1, patVal(e, r, 1'b1, byp, en), tag);
      pushOne(e, 1'b0, patVal(e, r, 1'b0, byp, en), tag);
    end
  endtask

  task automatic pushLow(int from, int to, logic [2:0] byp, logic [2:0] en, string tag);
    for (int e = from; e <= to; e++) begin
      pushOne(e, 1'b1, byp & en, tag);
      pushOne(e, 1'b0, 3'b000, tag);
    end
  endtask

  task automatic sample(bit hi);
    while (sb.size() > 0 && (sb[0].edgeNo < ecnt || (sb[0].edgeNo == ecnt && sb[0].hiPh == hi))) begin
      expItem_t it = sb.pop_front();
      checks++;
      if (it.edgeNo < ecnt) begin
        fails++;
        $display("FAIL %s missed sample edge=%0d actual=%b expected=%b", it.tag, it.edgeNo, chanOut, it.val);
      end else if (chanOut !== it.val) begin
        fails++;
        $display("FAIL %s edge=%0d phase=%0d actual=%b expected=%b", it.tag, it.edgeNo, hi, chanOut, it.val);
      end
    end
  endtask

  // monitor: one sample in the middle of each clock phase
  initial forever begin
    @(posedge distClk); #5; sample(1'b1);
    @(negedge distClk); #5; sample(1'b0);
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // called at a negedge; the load is sampled on the next edge
  task automatic loadCfg(logic [2:0] byp, logic [2:0] en, logic gen);
    cfgBypass = byp; cfgChanEn = en; cfgGlobalEn = gen;
    cfgDiv = {4'd4, 4'd2, 4'd0};
    cfgLoad = 1'b1;
    @(negedge distClk);
    cfgLoad = 1'b0;
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(negedge distClk);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int es, r0, r1, r2, e0;
    repeat (3) @(negedge distClk);
    rst = 1'b0;
    // R1: nothing shows before a configuration load
    pushPat(ecnt + 1, ecnt + 4, 0, 3'b001, 3'b000, "R1");
    drain();

    // R2 R4 R5 R3: bypass ch0, ratio 2 on ch1, ratio 4 on ch2, 6-cycle sync
    loadCfg(3'b001, 3'b111, 1'b1);
    es = ecnt;
    syncN = 1'b0;
    r0 = es + 6 + 9;
    pushLow(es + 9, r0 - 1, 3'b001, 3'b111, "R2 R4");
    pushPat(r0, r0 + 11, r0, 3'b001, 3'b111, "R5 R3");
    repeat (6) @(negedge distClk);
    syncN = 1'b1;
    drain();

    // R6: single-cycle low pulse leaves the outputs undisturbed
    pushPat(ecnt + 1, ecnt + 14, r0, 3'b001, 3'b111, "R6");
    syncN = 1'b0;
    @(negedge distClk);
    syncN = 1'b1;
    drain();

    // R7: release before the outputs go low
    e0 = ecnt;
    syncN = 1'b0;
    pushPat(e0 + 1, e0 + 8, r0, 3'b001, 3'b111, "R7");
    pushLow(e0 + 9, e0 + 10, 3'b001, 3'b111, "R7");
    r1 = e0 + 11;
    pushPat(r1, r1 + 7, r1, 3'b001, 3'b111, "R7");
    repeat (2) @(negedge distClk);
    syncN = 1'b1;
    drain();

    // R8: gate ch1 off, then back on in phase
    e0 = ecnt;
    pushPat(e0 + 1, e0 + 4, r1, 3'b001, 3'b101, "R8");
    loadCfg(3'b001, 3'b101, 1'b1);
    repeat (3) @(negedge distClk);
    pushPat(e0 + 5, e0 + 10, r1, 3'b001, 3'b111, "R8");
    loadCfg(3'b001, 3'b111, 1'b1);
    drain();

    // R9: global pin low then high
    e0 = ecnt;
    outEnPin = 1'b0;
    pushPat(e0 + 1, e0 + 3, r1, 3'b001, 3'b000, "R9");
    pushPat(e0 + 4, e0 + 9, r1, 3'b001, 3'b111, "R9");
    repeat (3) @(negedge distClk);
    outEnPin = 1'b1;
    drain();

    // R10: global enable bit cleared then set
    e0 = ecnt;
    pushPat(e0 + 1, e0 + 3, r1, 3'b001, 3'b000, "R10");
    pushPat(e0 + 4, e0 + 8, r1, 3'b001, 3'b111, "R10");
    loadCfg(3'b001, 3'b111, 1'b0);
    repeat (2) @(negedge distClk);
    loadCfg(3'b001, 3'b111, 1'b1);
    drain();

    // R3 R4: ch0 divided with ratio field 0, resynchronized with the others
    loadCfg(3'b000, 3'b111, 1'b1);
    es = ecnt;
    syncN = 1'b0;
    r2 = es + 3 + 9;
    pushLow(es + 9, r2 - 1, 3'b000, 3'b111, "R4");
    pushPat(r2, r2 + 7, r2, 3'b000, 3'b111, "R3");
    repeat (3) @(negedge distClk);
    syncN = 1'b1;
    drain();

    finishRun();
  end
endmodule